// File: doc/BRIEF.md
# Halt and Wake-Up Controller

This block stops a small microcontroller core to save power and brings it back without losing state. A halt can start in two ways. An active-low halt pin pulled low stops the core from the outside. Software can also stop the core itself by clearing the wake latch (discrete latch 15) while internal halt is enabled. The block drives a hold signal that freezes the core clock. It also sets the I/O pads either to hold their last value or to float with pull-ups off.

The two halt kinds are released in different ways. An external halt ends only when the pin goes high again. An internal halt ends on a prescaler overflow pulse, which sets the wake latch again and sends one increment to the timer register. After either release the core stays held for a fixed number of instruction-cycle ticks. These ticks come from a free-running oscillator that keeps running while the core clock is stopped.

The sixteen discrete output latches are part of this block because one of them is the internal halt trigger. Software can write them only while the core is running. The halt pin is assumed to be synchronised to `clk` already.

Top module: `halt_wake_ctrl`

## Requirements
- R1: While `rst` is high and in the first cycle after it, all sixteen discrete latches read 1, `coreHold`, `timerInc`, `ioHold` and `ioHiZ` are 0, and `pullUpEn` is 1.
- R2: With the core running, `haltPinN` low at a clock edge makes `coreHold` 1 after that edge. It stays 1 for as long as the pin stays low.
- R3: With `cfgIntHaltEn` = 1 and the core running, a write of value 0 to index 15 sets `discLatch[15]` to 0 and `coreHold` to 1 after the same edge.
- R4: During an internal halt with the pin high, a `prescOvf` pulse sets `discLatch[15]` back to 1 and makes `timerInc` a single-cycle pulse in the cycle after the overflow edge.
- R5: During an external halt, `prescOvf` has no effect: no `timerInc`, no latch change, and `coreHold` stays 1.
- R6: After a release edge (pin returning high, or an overflow during internal halt), `coreHold` stays 1 until exactly 16 `cycleTick` pulses have been sampled on the following edges. It falls at the edge that samples the sixteenth pulse.
- R7: With `cfgIoHiZ` = 0: `ioHold` equals `coreHold`, `ioHiZ` is 0 and `pullUpEn` is 1. With `cfgIoHiZ` = 1: `ioHiZ` equals `coreHold`, `pullUpEn` is its inverse and `ioHold` is 0.
- R8: With `cfgIntHaltEn` = 0, clearing latch 15 does not halt the core and `prescOvf` does not change the latch. `crystalMode` always equals `cfgIntHaltEn`, which marks discrete pins 14 and 15 as crystal pins.
- R9: A low pin during an internal halt takes priority. An overflow while the pin is low is ignored. After the pin goes high and the delay ends, the internal halt resumes while latch 15 is still 0.
- R10: Latch writes made while `coreHold` is 1 are dropped.
- R11: A low pin during the post-release delay returns the block to external halt and clears the count. A later release needs a full 16 ticks again.
- R12: While the core is running, a write of `wrVal` to index `wrIdx` updates that latch, and a write of 1 to index 15 never halts the core.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| haltPinN | input | 1 | External halt request, active low |
| cycleTick | input | 1 | Instruction-cycle tick from the free-running oscillator |
| prescOvf | input | 1 | Prescaler overflow pulse |
| cfgIntHaltEn | input | 1 | Static option: internal halt available |
| cfgIoHiZ | input | 1 | Static option: float I/O during halt (else hold it) |
| wrEn | input | 1 | Discrete latch write strobe from the core |
| wrIdx | input | 4 | Discrete latch index |
| wrVal | input | 1 | Value to write |
| discLatch | output | 16 | Discrete output latch values |
| coreHold | output | 1 | Stops the core clock |
| timerInc | output | 1 | One-cycle timer register increment |
| ioHold | output | 1 | Pads keep their last value |
| ioHiZ | output | 1 | Pads float |
| pullUpEn | output | 1 | Pad pull-up enable |
| crystalMode | output | 1 | Pins 14 and 15 used for the crystal |

## Verification
The halt function is exercised with four entry and release patterns:
- a plain pin-driven halt with an overflow arriving during it;
- a software halt woken by an overflow;
- a software halt overridden by the pin;
- a pin pulse that lands in the middle of the restart delay.

Together these separate the two release rules and show that the delay restarts from zero.

A tick that fires on one clock in three keeps the delay count apart from a clock count. Runs with internal halt disabled and with floating pads separate the configuration variants. Writes attempted during a halt show whether the latches are truly frozen.

// File: rtl/halt_pkg.sv
package halt_pkg;
  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_EXT  = 2'd1,
    ST_INT  = 2'd2,
    ST_WAIT = 2'd3
  } haltState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic wrOk;      // latch writes accepted (core running)
    logic setWake;   // force wake latch back to 1
    logic bumpTimer; // request timer increment
    logic hold;      // core clock stopped
  } haltStrobe_t;
endpackage

// File: rtl/halt_ctrl.sv
module halt_ctrl
  import halt_pkg::*;
#(
  parameter int DELAY_TICKS = 16,
  parameter int IDX_W       = 4,
  parameter int WAKE_BIT    = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             haltPinN,
  input  logic             cycleTick,
  input  logic             prescOvf,
  input  logic             intHaltEn,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic             wrVal,
  input  logic             wakeLatch,
  output haltStrobe_t      strobe
);
  localparam int CNT_W = $clog2(DELAY_TICKS);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(DELAY_TICKS - 1);

  haltState_t state, nextState;
  logic [CNT_W-1:0] tickCnt;
  logic swHaltReq, ovfWake, delayDone;

  assign swHaltReq = wrEn && (wrIdx == IDX_W'(WAKE_BIT)) && !wrVal && intHaltEn;
  assign ovfWake   = (state == ST_INT) && haltPinN && prescOvf;
  assign delayDone = (state == ST_WAIT) && cycleTick && (tickCnt == LAST_CNT);

  always_comb begin
    nextState = state;
    case (state)
      ST_RUN: begin
        if (!haltPinN)      nextState = ST_EXT;
        else if (swHaltReq) nextState = ST_INT;
      end
      ST_EXT: begin
        if (haltPinN) nextState = ST_WAIT;
      end
      ST_INT: begin
        if (!haltPinN)    nextState = ST_EXT;
        else if (ovfWake) nextState = ST_WAIT;
      end
      ST_WAIT: begin
        if (!haltPinN) nextState = ST_EXT;
        else if (delayDone)
          nextState = (intHaltEn && !wakeLatch) ? ST_INT : ST_RUN;
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state <= ST_RUN;
    else     state <= nextState;
  end

  // Counter is zero outside the wait state and on every exit from it
  always_ff @(posedge clk) begin
    if (rst || state != ST_WAIT || nextState != ST_WAIT) tickCnt <= '0;
    else if (cycleTick)                                  tickCnt <= tickCnt + 1'b1;
  end

  always_comb begin
    strobe.wrOk      = (state == ST_RUN);
    strobe.hold      = (state != ST_RUN);
    strobe.setWake   = ovfWake;
    strobe.bumpTimer = ovfWake;
  end
endmodule

// File: rtl/halt_dpath.sv
module halt_dpath
  import halt_pkg::*;
#(
  parameter int N_DISC   = 16,
  parameter int IDX_W    = 4,
  parameter int WAKE_BIT = 15
) (
  input  logic              clk,
  input  logic              rst,
  input  haltStrobe_t       strobe,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrVal,
  input  logic              cfgIoHiZ,
  output logic [N_DISC-1:0] discLatch,
  output logic              timerInc,
  output logic              ioHold,
  output logic              ioHiZ,
  output logic              pullUpEn
);
  for (genvar i = 0; i < N_DISC; i++) begin : g_latch
    logic hit;
    assign hit = strobe.wrOk && wrEn && (wrIdx == IDX_W'(i));
    if (i == WAKE_BIT) begin : g_wake
      always_ff @(posedge clk) begin
        if (rst || strobe.setWake) discLatch[i] <= 1'b1;
        else if (hit)              discLatch[i] <= wrVal;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)      discLatch[i] <= 1'b1;
        else if (hit) discLatch[i] <= wrVal;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) timerInc <= 1'b0;
    else     timerInc <= strobe.bumpTimer;
  end

  always_comb begin
    ioHold   = strobe.hold && !cfgIoHiZ;
    ioHiZ    = strobe.hold && cfgIoHiZ;
    pullUpEn = !ioHiZ;
  end
endmodule

// File: rtl/halt_wake_ctrl.sv
module halt_wake_ctrl
  import halt_pkg::*;
#(
  parameter int N_DISC      = 16,
  parameter int WAKE_BIT    = 15,
  parameter int DELAY_TICKS = 16,
  localparam int IDX_W      = $clog2(N_DISC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              haltPinN,
  input  logic              cycleTick,
  input  logic              prescOvf,
  input  logic              cfgIntHaltEn,
  input  logic              cfgIoHiZ,
  input  logic              wrEn,
  input  logic [IDX_W-1:0]  wrIdx,
  input  logic              wrVal,
  output logic [N_DISC-1:0] discLatch,
  output logic              coreHold,
  output logic              timerInc,
  output logic              ioHold,
  output logic              ioHiZ,
  output logic              pullUpEn,
  output logic              crystalMode
);
  haltStrobe_t strobe;

  halt_ctrl #(.DELAY_TICKS(DELAY_TICKS), .IDX_W(IDX_W), .WAKE_BIT(WAKE_BIT)) ctrl_i (
    .clk(clk), .rst(rst), .haltPinN(haltPinN), .cycleTick(cycleTick),
    .prescOvf(prescOvf), .intHaltEn(cfgIntHaltEn), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrVal(wrVal), .wakeLatch(discLatch[WAKE_BIT]), .strobe(strobe)
  );

  halt_dpath #(.N_DISC(N_DISC), .IDX_W(IDX_W), .WAKE_BIT(WAKE_BIT)) dpath_i (
    .clk(clk), .rst(rst), .strobe(strobe), .wrEn(wrEn), .wrIdx(wrIdx),
    .wrVal(wrVal), .cfgIoHiZ(cfgIoHiZ), .discLatch(discLatch),
    .timerInc(timerInc), .ioHold(ioHold), .ioHiZ(ioHiZ), .pullUpEn(pullUpEn)
  );

  assign coreHold    = strobe.hold;
  assign crystalMode = cfgIntHaltEn;
endmodule

// File: rtl/halt_wake_chk.sv
module halt_wake_chk #(
  parameter int N_DISC   = 16,
  parameter int WAKE_BIT = 15
) (
  input logic              clk,
  input logic              rst,
  input logic              haltPinN,
  input logic              prescOvf,
  input logic              cfgIoHiZ,
  input logic [N_DISC-1:0] discLatch,
  input logic              coreHold,
  input logic              timerInc,
  input logic              ioHold,
  input logic              ioHiZ,
  input logic              pullUpEn
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (&discLatch && !coreHold && !timerInc));

  a_r2_pin_low_halts: assert property (@(posedge clk) disable iff (rst)
    !haltPinN |=> coreHold);

  a_r4_inc_sets_wake: assert property (@(posedge clk) disable iff (rst)
    timerInc |-> (discLatch[WAKE_BIT] && $past(prescOvf) && coreHold));

  a_r4_inc_single: assert property (@(posedge clk) disable iff (rst)
    timerInc |=> !timerInc);

  a_r5_ext_no_wake: assert property (@(posedge clk) disable iff (rst)
    (!haltPinN && coreHold) |=> (!timerInc && coreHold));

  a_r7_pads_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(ioHold && ioHiZ) && (pullUpEn == !ioHiZ));

  a_r7_pads_follow: assert property (@(posedge clk) disable iff (rst)
    coreHold |-> (cfgIoHiZ ? ioHiZ : ioHold));

  a_r10_frozen_latches: assert property (@(posedge clk) disable iff (rst)
    coreHold |=> $stable(discLatch[WAKE_BIT-1:0]));
endmodule

bind halt_wake_ctrl halt_wake_chk #(.N_DISC(N_DISC), .WAKE_BIT(WAKE_BIT)) chk_i (
  .clk(clk), .rst(rst), .haltPinN(haltPinN), .prescOvf(prescOvf),
  .cfgIoHiZ(cfgIoHiZ), .discLatch(discLatch), .coreHold(coreHold),
  .timerInc(timerInc), .ioHold(ioHold), .ioHiZ(ioHiZ), .pullUpEn(pullUpEn)
);

// File: tb/halt_wake_ctrl_tb_top.sv
module halt_wake_ctrl_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic haltPinN = 1'b1, cycleTick = 1'b0, prescOvf = 1'b0;
  logic cfgIntHaltEn = 1'b1, cfgIoHiZ = 1'b0;
  logic wrEn = 1'b0, wrVal = 1'b0;
  logic [3:0] wrIdx = '0;
  logic [15:0] discLatch;
  logic coreHold, timerInc, ioHold, ioHiZ, pullUpEn, crystalMode;
  int checks = 0, failures = 0;
  int tickDiv = 0;
  bit finished = 0;

  halt_wake_ctrl dut_i (
    .clk(clk), .rst(rst), .haltPinN(haltPinN), .cycleTick(cycleTick),
    .prescOvf(prescOvf), .cfgIntHaltEn(cfgIntHaltEn), .cfgIoHiZ(cfgIoHiZ),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrVal(wrVal), .discLatch(discLatch),
    .coreHold(coreHold), .timerInc(timerInc), .ioHold(ioHold), .ioHiZ(ioHiZ),
    .pullUpEn(pullUpEn), .crystalMode(crystalMode)
  );

  always #10 clk = ~clk;

  // Free-running tick: one clock in three
  always @(negedge clk) begin
    tickDiv   <= (tickDiv == 2) ? 0 : tickDiv + 1;
    cycleTick <= (tickDiv == 2);
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic doReset(input logic intEn, input logic hiZ);
    @(negedge clk);
    rst = 1'b1; haltPinN = 1'b1; prescOvf = 1'b0; wrEn = 1'b0;
    cfgIntHaltEn = intEn; cfgIoHiZ = hiZ;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic discWrite(input int idx, input logic val);
    wrEn = 1'b1; wrIdx = 4'(idx); wrVal = val;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  // Called at a negedge where a release condition has just been driven.
  task automatic measureRelease(output int ticks, output int incSeen, output int wakeSeen);
    int guard;
    @(posedge clk);              // release edge
    @(negedge clk);
    prescOvf = 1'b0;
    incSeen  = int'(timerInc);
    wakeSeen = int'(discLatch[15]);
    ticks = 0;
    guard = 0;
    while (guard < 300) begin
      @(posedge clk);
      if (cycleTick) ticks++;
      @(negedge clk);
      if (!coreHold) break;
      guard++;
    end
  endtask

  task automatic testReset();
    doReset(1'b1, 1'b0);
    chk("R1 latches", int'(discLatch), 16'hFFFF);
    chk("R1 coreHold", int'(coreHold), 0);
    chk("R1 timerInc", int'(timerInc), 0);
    chk("R1 pads", int'({ioHold, ioHiZ, pullUpEn}), 1);
  endtask

  task automatic testExtHalt();
    int t, inc, wk;
    doReset(1'b1, 1'b0);
    haltPinN = 1'b0;
    @(negedge clk);
    chk("R2 halt on pin", int'(coreHold), 1);
    chk("R7 hold mode pads", int'({ioHold, ioHiZ, pullUpEn}), 3'b101);
    discWrite(3, 1'b0);
    discWrite(15, 1'b0);
    prescOvf = 1'b1;
    @(negedge clk);
    prescOvf = 1'b0;
    repeat (4) @(negedge clk);
    chk("R2 still held", int'(coreHold), 1);
    chk("R5 ovf ignored in ext halt", int'(timerInc), 0);
    chk("R10 write dropped", int'(discLatch), 16'hFFFF);
    haltPinN = 1'b1;
    measureRelease(t, inc, wk);
    chk("R6 ext release ticks", t, 16);
    chk("R5 no increment on ext release", inc, 0);
    chk("R10 latches after halt", int'(discLatch), 16'hFFFF);
    chk("R6 running after delay", int'(coreHold), 0);
  endtask

  task automatic testIntHalt();
    int t, inc, wk;
    doReset(1'b1, 1'b0);
    chk("R8 crystal mode on", int'(crystalMode), 1);
    discWrite(5, 1'b0);
    chk("R12 run write", int'(discLatch[5]), 0);
    discWrite(15, 1'b1);
    chk("R12 write 1 no halt", int'(coreHold), 0);
    discWrite(15, 1'b0);
    chk("R3 soft halt", int'(coreHold), 1);
    chk("R3 wake latch clear", int'(discLatch[15]), 0);
    repeat (20) @(negedge clk);
    chk("R3 waits for overflow", int'(coreHold), 1);
    prescOvf = 1'b1;
    measureRelease(t, inc, wk);
    chk("R4 timerInc pulse", inc, 1);
    chk("R4 wake latch set", wk, 1);
    chk("R6 int release ticks", t, 16);
    chk("R4 pulse ended", int'(timerInc), 0);
    chk("R12 latch5 kept", int'(discLatch[5]), 0);
  endtask

  task automatic testPriority();
    int t, inc, wk;
    doReset(1'b1, 1'b1);
    discWrite(15, 1'b0);
    chk("R7 hiz pads", int'({ioHold, ioHiZ, pullUpEn}), 3'b010);
    haltPinN = 1'b0;
    @(negedge clk);
    prescOvf = 1'b1;
    @(negedge clk);
    prescOvf = 1'b0;
    chk("R9 ovf ignored under pin", int'(timerInc), 0);
    chk("R9 wake latch stays clear", int'(discLatch[15]), 0);
    haltPinN = 1'b1;
    repeat (80) @(negedge clk);
    chk("R9 internal halt resumes", int'(coreHold), 1);
    prescOvf = 1'b1;
    measureRelease(t, inc, wk);
    chk("R9 final overflow wakes", inc, 1);
    chk("R6 ticks after resume", t, 16);
    chk("R7 hiz released", int'({ioHold, ioHiZ, pullUpEn}), 3'b001);
  endtask

  task automatic testRestart();
    int t, inc, wk;
    doReset(1'b1, 1'b0);
    haltPinN = 1'b0;
    repeat (3) @(negedge clk);
    haltPinN = 1'b1;
    repeat (20) @(negedge clk);
    haltPinN = 1'b0;
    @(negedge clk);
    chk("R11 re-entered halt", int'(coreHold), 1);
    repeat (5) @(negedge clk);
    haltPinN = 1'b1;
    measureRelease(t, inc, wk);
    chk("R11 full count again", t, 16);
  endtask

  task automatic testIntDisabled();
    doReset(1'b0, 1'b0);
    chk("R8 crystal mode off", int'(crystalMode), 0);
    discWrite(15, 1'b0);
    chk("R8 no soft halt", int'(coreHold), 0);
    chk("R8 latch written", int'(discLatch[15]), 0);
    prescOvf = 1'b1;
    @(negedge clk);
    prescOvf = 1'b0;
    @(negedge clk);
    chk("R8 ovf no effect", int'({discLatch[15], timerInc, coreHold}), 0);
  endtask

  initial begin
    testReset();
    testExtHalt();
    testIntHalt();
    testPriority();
    testRestart();
    testIntDisabled();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule